// File: doc/BRIEF.md
# Capture Byte Read Sequencer

This block hands captured audio samples to a host one byte at a time over an 8-bit read-only data port. A sample word arrives from the capture FIFO on a valid strobe, together with a format code that sets how many bytes the sample holds. The block keeps the sample in a holding register and a byte pointer selects which byte the port shows. Each port read moves the pointer on by one. The pointer's value is also driven out as a status field, so software can tell which byte comes next.

The pointer does not wrap. After the last byte of a sample it stays on that byte, and further reads return the same value. It goes back to byte zero only when two things have both happened: a status read and the arrival of a new sample. A sample that arrives before the status read waits in a one-deep pending slot. If a newer sample arrives first, it replaces the one waiting. A status read with no sample waiting arms the block, and the next sample to arrive is then taken at once. While the power-down/initialisation flag is high, the port reads as a fixed code and all sequencing stops.

Top module: `cap_byte_seq`

## Requirements
- R1: Lane k of the sample word is bits [8k+7:8k]. For lanes 0 to 3 these are left low, left high, right low and right high. The port shows the lane at the pointer, and each port read moves the pointer on by one at the next clock edge.
- R2: `rd_pos` equals the index of the byte that the next port read returns.
- R3: The sample length comes from the format code in force when the sample is loaded: 0 gives 1 byte, 1 gives 2, 2 gives 2 and 3 gives 4. Once the pointer reaches the last byte it stays there, and repeated reads return that byte. A later change of the format input does not move that limit.
- R4: A sample is loaded, with the pointer set to 0, at the edge where a status read (in that cycle or earlier, still unused) and a sample (arriving in that cycle or pending) are both present. This includes a status read and a sample strobe in the same cycle.
- R5: A sample that arrives with no status read armed is held pending, and the port keeps its old value. A second arrival replaces the first. The pending sample is loaded at the edge of the next status read.
- R6: A status read with no sample arriving or pending leaves the pointer and the port data unchanged.
- R7: While `pwr_dn` is high, the port reads 0x80 in the same cycle, `rd_pos` reads 0, and port reads, status reads and sample strobes have no effect. At each edge with `pwr_dn` high, the holding register (which then reads 0 with a 1-byte length), the pointer, the pending slot and the arm are cleared.
- R8: A synchronous reset (`rst_n` low at an edge) sets the pointer to 0 and the holding register to 0 with a 1-byte length, and leaves nothing pending or armed.
- R9: When a load and a port read fall in the same cycle, the load takes effect and the pointer becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | New sample from the capture FIFO |
| smp_data | input | 32 | Sample word, lane 0 in the low byte |
| smp_fmt | input | 2 | Format code for the arriving sample |
| port_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status-register read strobe |
| pwr_dn | input | 1 | Power-down / initialisation flag |
| port_data | output | 8 | Byte presented on the data port |
| rd_pos | output | 2 | Status field: index of the next byte |

## Verification
Every strobe takes effect at the next rising edge, and port data and position come straight from registers. A read, load or pending capture therefore shows up in the cycle after its strobe. The exception is the power-down override, which reaches the outputs in the same cycle. The driver applies each stimulus just after a falling edge and queues what the outputs should show during that same cycle. The monitor compares one nanosecond later. Each result is thus checked in the cycle that follows the stimulus that caused it, and a same-cycle effect is checked in its own cycle.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'd0,
    FMT_STEREO8  = 2'd1,
    FMT_MONO16   = 2'd2,
    FMT_STEREO16 = 2'd3
  } cbs_fmt_e;

  // Index of the final byte of a sample in the given format.
  function automatic logic [1:0] fmt_last(cbs_fmt_e f);
    case (f)
      FMT_MONO8:               fmt_last = 2'd0;
      FMT_STEREO8, FMT_MONO16: fmt_last = 2'd1;
      default:                 fmt_last = 2'd3;
    endcase
  endfunction

  // Next pointer value for a read: advance, but never past the last byte.
  function automatic logic [1:0] ptr_step(logic [1:0] cur, logic [1:0] last);
    ptr_step = (cur < last) ? cur + 2'd1 : cur;
  endfunction

endpackage

// File: rtl/cbs_pending.sv
module cbs_pending #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arrive,
  input  logic              take,
  input  logic [WORD_W-1:0] in_data,
  input  cbs_pkg::cbs_fmt_e in_fmt,
  output logic              pend_v,
  output logic [WORD_W-1:0] pend_data,
  output cbs_pkg::cbs_fmt_e pend_fmt
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend_v    <= 1'b0;
      pend_data <= '0;
      pend_fmt  <= cbs_pkg::FMT_MONO8;
    end else if (take) begin
      pend_v <= 1'b0;
    end else if (arrive) begin
      pend_v    <= 1'b1;
      pend_data <= in_data;
      pend_fmt  <= in_fmt;
    end
  end

endmodule

// File: rtl/cbs_ptr.sv
module cbs_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stat_rd,
  input  logic             have_smp,
  input  logic             port_rd,
  input  logic [PTR_W-1:0] last_idx,
  output logic [PTR_W-1:0] ptr_q,
  output logic             armed_q,
  output logic             load
);

  assign load = (stat_rd | armed_q) & have_smp & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= (armed_q | stat_rd) & ~load;
      if (load)         ptr_q <= '0;
      else if (port_rd) ptr_q <= cbs_pkg::ptr_step(ptr_q, last_idx);
    end
  end

endmodule

// File: rtl/cbs_hold.sv
module cbs_hold #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PTR_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] src_data,
  input  cbs_pkg::cbs_fmt_e src_fmt,
  input  logic [PTR_W-1:0]  ptr,
  output logic [WORD_W-1:0] hold_q,
  output logic [PTR_W-1:0]  last_q,
  output logic [BYTE_W-1:0] byte_out
);

  logic [BYTE_W-1:0] lane [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hold_q <= '0;
      last_q <= '0;
    end else if (load) begin
      hold_q <= src_data;
      last_q <= PTR_W'(cbs_pkg::fmt_last(src_fmt));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = hold_q[g*BYTE_W +: BYTE_W];
  end

  assign byte_out = lane[ptr];

endmodule

// File: rtl/cap_byte_seq.sv
module cap_byte_seq #(
  parameter int          BYTE_W    = 8,
  parameter int          LANES     = 4,
  parameter logic [7:0]  IDLE_CODE = 8'h80,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PTR_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic [1:0]        smp_fmt,
  input  logic              port_rd,
  input  logic              stat_rd,
  input  logic              pwr_dn,
  output logic [BYTE_W-1:0] port_data,
  output logic [PTR_W-1:0]  rd_pos
);

  cbs_pkg::cbs_fmt_e in_fmt;
  cbs_pkg::cbs_fmt_e pend_fmt;
  cbs_pkg::cbs_fmt_e src_fmt;
  logic              pend_v;
  logic [WORD_W-1:0] pend_data;
  logic [WORD_W-1:0] src_data;
  logic [WORD_W-1:0] hold_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  last_q;
  logic [BYTE_W-1:0] cur_byte;
  logic              armed_q;
  logic              load_evt;
  logic              arrive_evt;
  logic              read_evt;
  logic              stat_evt;

  assign in_fmt     = cbs_pkg::cbs_fmt_e'(smp_fmt);
  assign arrive_evt = smp_valid & ~pwr_dn;
  assign read_evt   = port_rd & ~pwr_dn;
  assign stat_evt   = stat_rd & ~pwr_dn;

  // A sample in this cycle is newer than anything pending.
  assign src_data = smp_valid ? smp_data : pend_data;
  assign src_fmt  = smp_valid ? in_fmt   : pend_fmt;

  cbs_pending #(.WORD_W(WORD_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_dn),
    .arrive   (arrive_evt),
    .take     (load_evt),
    .in_data  (smp_data),
    .in_fmt   (in_fmt),
    .pend_v   (pend_v),
    .pend_data(pend_data),
    .pend_fmt (pend_fmt)
  );

  cbs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_dn),
    .stat_rd (stat_evt),
    .have_smp(arrive_evt | pend_v),
    .port_rd (read_evt),
    .last_idx(last_q),
    .ptr_q   (ptr_q),
    .armed_q (armed_q),
    .load    (load_evt)
  );

  cbs_hold #(.BYTE_W(BYTE_W), .LANES(LANES)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_dn),
    .load    (load_evt),
    .src_data(src_data),
    .src_fmt (src_fmt),
    .ptr     (ptr_q),
    .hold_q  (hold_q),
    .last_q  (last_q),
    .byte_out(cur_byte)
  );

  assign port_data = pwr_dn ? BYTE_W'(IDLE_CODE) : cur_byte;
  assign rd_pos    = pwr_dn ? '0 : ptr_q;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int PTR_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              port_rd,
  input logic              stat_rd,
  input logic              smp_valid,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [PTR_W-1:0]  last_q,
  input logic              armed_q,
  input logic              pend_v,
  input logic              load_evt,
  input logic [WORD_W-1:0] hold_q,
  input logic [BYTE_W-1:0] port_data
);

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !pwr_dn && !load_evt && ptr_q < last_q)
      |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  p_stick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !pwr_dn && !load_evt && ptr_q == last_q) |=> $stable(ptr_q));

  p_load_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ptr_q == '0);

  p_no_load_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !armed_q && !pwr_dn) |=> $stable(hold_q));

  p_stat_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !smp_valid && !pend_v && !port_rd && !pwr_dn)
      |=> ($stable(ptr_q) && $stable(hold_q)));

  p_idle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> port_data == 8'h80);

  p_pd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (ptr_q == '0 && !pend_v && !armed_q));

  p_read_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && port_rd) |=> ptr_q == '0);

endmodule

bind cap_byte_seq cbs_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .port_rd  (port_rd),
  .stat_rd  (stat_rd),
  .smp_valid(smp_valid),
  .ptr_q    (ptr_q),
  .last_q   (last_q),
  .armed_q  (armed_q),
  .pend_v   (pend_v),
  .load_evt (load_evt),
  .hold_q   (hold_q),
  .port_data(port_data)
);

// File: tb/cap_byte_seq_test.sv
`timescale 1ns/1ps
module cap_byte_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic [1:0]  smp_fmt = 2'd0;
  logic        port_rd = 1'b0;
  logic        stat_rd = 1'b0;
  logic        pwr_dn = 1'b0;
  logic [7:0]  port_data;
  logic [1:0]  rd_pos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp_data;
    logic [1:0] exp_pos;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  cap_byte_seq uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_fmt(smp_fmt), .port_rd(port_rd), .stat_rd(stat_rd), .pwr_dn(pwr_dn),
    .port_data(port_data), .rd_pos(rd_pos)
  );

  // Monitor: compares what the outputs show during each queued cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (port_data !== e.exp_data || rd_pos !== e.exp_pos) begin
          errors++;
          $display("FAIL %s: data=%h pos=%0d expected data=%h pos=%0d",
                   e.tag, port_data, rd_pos, e.exp_data, e.exp_pos);
        end
      end
    end
  end

  // Driver: one cycle of stimulus; optionally queues the outputs expected in that cycle.
  task automatic cyc(input bit rd, input bit st, input bit sv, input logic [31:0] d,
                     input logic [1:0] f, input bit pd, input bit chk,
                     input logic [7:0] ed, input logic [1:0] ep, input string tag);
    @(negedge clk);
    port_rd = rd; stat_rd = st; smp_valid = sv; smp_data = d; smp_fmt = f; pwr_dn = pd;
    if (chk) begin
      exp_t e;
      e.exp_data = ed; e.exp_pos = ep; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic rd(input logic [7:0] ed, input logic [1:0] ep, input string tag);
    cyc(1, 0, 0, '0, 2'd0, 0, 1, ed, ep, tag);
  endtask

  task automatic idle(input logic [7:0] ed, input logic [1:0] ep, input string tag);
    cyc(0, 0, 0, '0, 2'd0, 0, 1, ed, ep, tag);
  endtask

  initial begin
    #160000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: data=%h pos=%0d expected run end", port_data, rd_pos);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8'h00, 2'd0, "R8 reset state");

    // Arm, then a 4-byte sample: bytes in lane order, then stick on the last.
    cyc(0, 1, 0, '0, 2'd0, 0, 0, '0, '0, "");
    cyc(0, 0, 1, 32'h4433_2211, 2'd3, 0, 0, '0, '0, "");
    rd(8'h11, 2'd0, "R4 armed load byte0");
    rd(8'h22, 2'd1, "R1 lane1");
    rd(8'h33, 2'd2, "R2 pos2");
    rd(8'h44, 2'd3, "R1 lane3");
    rd(8'h44, 2'd3, "R3 stick 4-byte");
    idle(8'h44, 2'd3, "R3 stick held");

    // Sample with no status read: pending, old data stays.
    cyc(0, 0, 1, 32'h0000_BBAA, 2'd1, 0, 1, 8'h44, 2'd3, "R5 arrival cycle");
    idle(8'h44, 2'd3, "R5 pending not loaded");
    cyc(0, 1, 0, '0, 2'd0, 0, 1, 8'h44, 2'd3, "R5 status read cycle");
    rd(8'hAA, 2'd0, "R5 pending loaded");
    rd(8'hBB, 2'd1, "R1 stereo8 byte1");
    rd(8'hBB, 2'd1, "R3 stick 2-byte");

    // Status read alone: no change; later sample loads immediately.
    cyc(0, 1, 0, '0, 2'd0, 0, 1, 8'hBB, 2'd1, "R6 status cycle");
    idle(8'hBB, 2'd1, "R6 no change");
    cyc(0, 0, 1, 32'h0000_00CC, 2'd0, 0, 1, 8'hBB, 2'd1, "R4 sample cycle");
    rd(8'hCC, 2'd0, "R4 load after arm");
    rd(8'hCC, 2'd0, "R3 stick 1-byte");

    // Two arrivals before the status read: newest wins.
    cyc(0, 0, 1, 32'h0000_1111, 2'd2, 0, 0, '0, '0, "");
    cyc(0, 0, 1, 32'h0000_2322, 2'd2, 0, 0, '0, '0, "");
    cyc(0, 1, 0, '0, 2'd0, 0, 1, 8'hCC, 2'd0, "R5 before status");
    rd(8'h22, 2'd0, "R5 newest replaces");
    rd(8'h23, 2'd1, "R1 mono16 high");
    rd(8'h23, 2'd1, "R3 stick mono16");

    // Load and port read in the same cycle.
    cyc(0, 1, 0, '0, 2'd0, 0, 0, '0, '0, "");
    cyc(1, 0, 1, 32'h8877_6655, 2'd3, 0, 1, 8'h23, 2'd1, "R9 collide cycle");
    rd(8'h55, 2'd0, "R9 load wins");
    rd(8'h66, 2'd1, "R1 after collide");

    // Status read and sample in the same cycle.
    cyc(0, 1, 1, 32'h0000_9A99, 2'd1, 0, 1, 8'h77, 2'd2, "R4 same-cycle pair");
    cyc(1, 0, 0, '0, 2'd3, 0, 1, 8'h99, 2'd0, "R4 same-cycle loaded");
    cyc(1, 0, 0, '0, 2'd3, 0, 1, 8'h9A, 2'd1, "R3 format at load");
    cyc(0, 0, 0, '0, 2'd3, 0, 1, 8'h9A, 2'd1, "R3 fmt change ignored");

    // Power-down: fixed code, all strobes ignored, state cleared.
    cyc(0, 0, 0, '0, 2'd0, 1, 1, 8'h80, 2'd0, "R7 idle code");
    cyc(1, 0, 1, 32'h0000_ADDE, 2'd1, 1, 1, 8'h80, 2'd0, "R7 read in pd");
    cyc(0, 1, 0, '0, 2'd0, 1, 1, 8'h80, 2'd0, "R7 status in pd");
    idle(8'h00, 2'd0, "R7 cleared after pd");
    cyc(0, 1, 0, '0, 2'd0, 0, 1, 8'h00, 2'd0, "R7 status after pd");
    idle(8'h00, 2'd0, "R7 pd sample not pending");
    cyc(0, 0, 1, 32'h0000_005A, 2'd0, 0, 1, 8'h00, 2'd0, "R4 arm then sample");
    idle(8'h5A, 2'd0, "R4 loaded after pd");

    // Synchronous reset mid-run.
    cyc(0, 0, 1, 32'h0000_7E7D, 2'd1, 0, 0, '0, '0, "");
    @(negedge clk); smp_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 1, 0, '0, 2'd0, 0, 1, 8'h00, 2'd0, "R8 reset clears");
    idle(8'h00, 2'd0, "R8 nothing pending");

    @(negedge clk); port_rd = 0; stat_rd = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule